// File: doc/BRIEF.md
# Speculation Barrier Gate

This block sits at the dispatch point of an out-of-order core. It decides when an operation that must not run speculatively may leave. Some reads have side effects: reads of device registers and of some privileged control registers. Such a read must wait until nothing older in the machine can still redirect it. That means no older conditional branch is left unresolved, and no older instruction can still raise an exception. Stores wait until they become the oldest entry in the reorder buffer.

The gate keeps two bit vectors indexed by reorder-buffer slot. One holds outstanding conditional branches and the other holds instructions that might still fault. Age is measured from the reorder-buffer head, so slot indices may wrap. One operation at a time is presented on the request port. When an operation can leave, a single-cycle grant pulse is raised, in the same cycle that its last blocker clears. Otherwise the operation is held and the stall output stays high. A flush removes tracking entries from the flush slot onward. If the flush covers the held operation, the operation is cancelled. A per-register table, set by parameter, marks control registers whose reads are free of side effects. Reads of those registers pass without waiting.

Top module: `specgate_gate`

## Requirements
- R1: A barrier request (kind code 1) is not granted while any branch slot older than its own slot is outstanding. It is granted in the same cycle that the last such branch is resolved.
- R2: A barrier is also held by older slots marked as possibly faulting. It is granted only in the cycle when both the older branches and the older faulting slots are clear.
- R3: Outstanding entries at slots younger than the request slot do not hold it. Age is (slot − head) modulo the reorder-buffer depth.
- R4: A control-register read (kind code 2) whose address n has bit n of the safety mask parameter set is granted in the cycle it is requested, whatever is outstanding. When bit n is clear, the read behaves exactly like a barrier.
- R5: A store (kind code 3) is granted only in a cycle in which its slot equals the head slot.
- R6: A plain operation (kind code 0) is granted in the cycle it is requested, even while older entries are outstanding.
- R7: A request that cannot be granted is held. While it is held, stall is high, ready is low and grant is low, until the cycle of its grant. A grant lasts one cycle, and ready returns in the cycle after it.
- R8: A flush whose slot is at or older than the held operation's slot cancels that operation in the flush cycle, with no grant. Ready returns in the next cycle. A flush younger than the held operation leaves it stalled.
- R9: A flush clears the tracking bits of every slot at or younger than the flush slot, so those slots no longer hold later barriers. Older bits are kept.
- R10: After reset, no slot is tracked, ready is high, and grant and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headSlot | input | IDX_W | Slot of the oldest reorder-buffer entry |
| brAllocValid | input | 1 | Mark a slot as an unresolved branch |
| brAllocSlot | input | IDX_W | Slot of the new branch |
| brResolveValid | input | 1 | A branch has resolved |
| brResolveSlot | input | IDX_W | Slot of the resolved branch |
| fltAllocValid | input | 1 | Mark a slot as possibly faulting |
| fltAllocSlot | input | IDX_W | Slot of the possibly faulting instruction |
| fltClearValid | input | 1 | An instruction has been found not to fault |
| fltClearSlot | input | IDX_W | Slot found fault-free |
| flushValid | input | 1 | Flush from a slot onward |
| flushSlot | input | IDX_W | Oldest slot removed by the flush |
| reqValid | input | 1 | Operation presented to the gate |
| reqKind | input | 2 | 0 plain, 1 barrier, 2 control-register read, 3 store |
| reqSlot | input | IDX_W | Slot of the operation |
| reqCsr | input | CSR_ADDR_W | Control-register address for kind 2 |
| reqReady | output | 1 | Gate holds no operation |
| gntValid | output | 1 | One-cycle release of the current operation |
| gntSlot | output | IDX_W | Slot of the released operation |
| gntKind | output | 2 | Kind of the released operation |
| stall | output | 1 | Current operation is being held |

## Verification
The checker watches every cycle for the following. Grant and stall are never high together. A stall is always followed by low ready, and it continues until a grant or a flush. A granted store always sits at the head. No granted slot lies inside a flush. Plain requests and safe-register reads are granted on arrival. Whether a barrier is held exactly by older entries and released in the very cycle of the last resolve is shown only by the bench. The bench sweeps every head position and every order of blocker and barrier over a small reorder buffer. It also covers every register address of the table and flushes on both sides of a held barrier.

// File: rtl/specgate_pkg.sv
package specgate_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN   = 2'd0,
    KIND_BARRIER = 2'd1,
    KIND_CSR     = 2'd2,
    KIND_STORE   = 2'd3
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the incoming request into the hold register
    logic release_;  // drop the held request (granted or cancelled)
  } gateStrobe_t;
endpackage

// File: rtl/specgate_csr_table.sv
module specgate_csr_table #(
  parameter int CSR_ADDR_W = 4,
  localparam int N_CSR = 1 << CSR_ADDR_W,
  parameter logic [N_CSR-1:0] SAFE_MASK = '0
) (
  input  logic [CSR_ADDR_W-1:0] addr,
  output logic                  safe
);
  logic [N_CSR-1:0] safeVec;

  for (genvar i = 0; i < N_CSR; i++) begin : g_reg
    assign safeVec[i] = SAFE_MASK[i];
  end

  assign safe = safeVec[addr];
endmodule

// File: rtl/specgate_track.sv
module specgate_track
  import specgate_pkg::*;
#(
  parameter int ROB_DEPTH  = 32,
  parameter int CSR_ADDR_W = 4,
  localparam int IDX_W = $clog2(ROB_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IDX_W-1:0]      headSlot,
  input  logic                  brAllocValid,
  input  logic [IDX_W-1:0]      brAllocSlot,
  input  logic                  brResolveValid,
  input  logic [IDX_W-1:0]      brResolveSlot,
  input  logic                  fltAllocValid,
  input  logic [IDX_W-1:0]      fltAllocSlot,
  input  logic                  fltClearValid,
  input  logic [IDX_W-1:0]      fltClearSlot,
  input  logic                  flushValid,
  input  logic [IDX_W-1:0]      flushSlot,
  input  logic                  pending,
  input  gateStrobe_t           strobe,
  input  logic [IDX_W-1:0]      reqSlot,
  input  opKind_t               reqKind,
  input  logic [CSR_ADDR_W-1:0] reqCsr,
  output logic [IDX_W-1:0]      activeSlot,
  output opKind_t               activeKind,
  output logic [CSR_ADDR_W-1:0] activeCsr,
  output logic                  olderBlock,
  output logic                  activeKilled,
  output logic                  atHead
);
  logic [ROB_DEPTH-1:0] brVec, fltVec, olderHit;
  logic [IDX_W-1:0]      heldSlot, activeAge, flushAge;
  opKind_t               heldKind;
  logic [CSR_ADDR_W-1:0] heldCsr;

  // hold register for one waiting operation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldSlot <= '0;
      heldKind <= KIND_PLAIN;
      heldCsr  <= '0;
    end else if (strobe.capture) begin
      heldSlot <= reqSlot;
      heldKind <= reqKind;
      heldCsr  <= reqCsr;
    end
  end

  assign activeSlot   = pending ? heldSlot : reqSlot;
  assign activeKind   = pending ? heldKind : reqKind;
  assign activeCsr    = pending ? heldCsr  : reqCsr;
  assign activeAge    = activeSlot - headSlot;
  assign flushAge     = flushSlot - headSlot;
  assign activeKilled = flushValid && (activeAge >= flushAge);
  assign atHead       = (activeSlot == headSlot);

  for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_entry
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    logic [IDX_W-1:0] entryAge;
    logic brClr, fltClr, flushHit, brSet, fltSet, brLive, fltLive;

    assign entryAge = SLOT - headSlot;
    assign flushHit = flushValid && (entryAge >= flushAge);
    assign brClr    = brResolveValid && (brResolveSlot == SLOT);
    assign fltClr   = fltClearValid && (fltClearSlot == SLOT);
    assign brSet    = brAllocValid && (brAllocSlot == SLOT);
    assign fltSet   = fltAllocValid && (fltAllocSlot == SLOT);
    assign brLive   = brVec[i] && !brClr;
    assign fltLive  = fltVec[i] && !fltClr;

    // resolves in this cycle already count as cleared
    assign olderHit[i] = (brLive || fltLive) && (entryAge < activeAge);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        brVec[i]  <= 1'b0;
        fltVec[i] <= 1'b0;
      end else begin
        brVec[i]  <= (brLive && !flushHit) || brSet;
        fltVec[i] <= (fltLive && !flushHit) || fltSet;
      end
    end
  end

  assign olderBlock = |olderHit;
endmodule

// File: rtl/specgate_ctrl.sv
module specgate_ctrl
  import specgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  opKind_t     activeKind,
  input  logic        olderBlock,
  input  logic        activeKilled,
  input  logic        atHead,
  input  logic        csrSafe,
  output logic        pending,
  output gateStrobe_t strobe,
  output logic        gntValid,
  output logic        stall,
  output logic        reqReady
);
  logic hasReq, needWait;

  always_comb begin
    unique case (activeKind)
      KIND_PLAIN:   needWait = 1'b0;
      KIND_BARRIER: needWait = olderBlock;
      KIND_CSR:     needWait = !csrSafe && olderBlock;
      KIND_STORE:   needWait = !atHead;
      default:      needWait = 1'b0;
    endcase
  end

  assign hasReq   = pending || reqValid;
  assign gntValid = hasReq && !activeKilled && !needWait;
  assign stall    = hasReq && !activeKilled && needWait;
  assign reqReady = !pending;

  assign strobe.capture  = reqValid && !pending && stall;
  assign strobe.release_ = pending && (gntValid || activeKilled);

  always_ff @(posedge clk) begin
    if (!rstN)                 pending <= 1'b0;
    else if (strobe.capture)   pending <= 1'b1;
    else if (strobe.release_)  pending <= 1'b0;
  end
endmodule

// File: rtl/specgate_gate.sv
module specgate_gate
  import specgate_pkg::*;
#(
  parameter int ROB_DEPTH  = 32,
  parameter int CSR_ADDR_W = 4,
  localparam int IDX_W = $clog2(ROB_DEPTH),
  localparam int N_CSR = 1 << CSR_ADDR_W,
  parameter logic [N_CSR-1:0] CSR_SAFE_MASK = 16'h00F3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IDX_W-1:0]      headSlot,
  input  logic                  brAllocValid,
  input  logic [IDX_W-1:0]      brAllocSlot,
  input  logic                  brResolveValid,
  input  logic [IDX_W-1:0]      brResolveSlot,
  input  logic                  fltAllocValid,
  input  logic [IDX_W-1:0]      fltAllocSlot,
  input  logic                  fltClearValid,
  input  logic [IDX_W-1:0]      fltClearSlot,
  input  logic                  flushValid,
  input  logic [IDX_W-1:0]      flushSlot,
  input  logic                  reqValid,
  input  logic [1:0]            reqKind,
  input  logic [IDX_W-1:0]      reqSlot,
  input  logic [CSR_ADDR_W-1:0] reqCsr,
  output logic                  reqReady,
  output logic                  gntValid,
  output logic [IDX_W-1:0]      gntSlot,
  output logic [1:0]            gntKind,
  output logic                  stall
);
  gateStrobe_t           strobe;
  logic                  pending, olderBlock, activeKilled, atHead, csrSafe;
  logic [IDX_W-1:0]      activeSlot;
  opKind_t               activeKind;
  logic [CSR_ADDR_W-1:0] activeCsr;

  specgate_track #(.ROB_DEPTH(ROB_DEPTH), .CSR_ADDR_W(CSR_ADDR_W)) u_track (
    .clk(clk), .rstN(rstN), .headSlot(headSlot),
    .brAllocValid(brAllocValid), .brAllocSlot(brAllocSlot),
    .brResolveValid(brResolveValid), .brResolveSlot(brResolveSlot),
    .fltAllocValid(fltAllocValid), .fltAllocSlot(fltAllocSlot),
    .fltClearValid(fltClearValid), .fltClearSlot(fltClearSlot),
    .flushValid(flushValid), .flushSlot(flushSlot),
    .pending(pending), .strobe(strobe),
    .reqSlot(reqSlot), .reqKind(opKind_t'(reqKind)), .reqCsr(reqCsr),
    .activeSlot(activeSlot), .activeKind(activeKind), .activeCsr(activeCsr),
    .olderBlock(olderBlock), .activeKilled(activeKilled), .atHead(atHead)
  );

  specgate_csr_table #(.CSR_ADDR_W(CSR_ADDR_W), .SAFE_MASK(CSR_SAFE_MASK)) u_table (
    .addr(activeCsr), .safe(csrSafe)
  );

  specgate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .activeKind(activeKind), .olderBlock(olderBlock),
    .activeKilled(activeKilled), .atHead(atHead), .csrSafe(csrSafe),
    .pending(pending), .strobe(strobe),
    .gntValid(gntValid), .stall(stall), .reqReady(reqReady)
  );

  assign gntSlot = activeSlot;
  assign gntKind = activeKind;
endmodule

// File: rtl/specgate_gate_chk.sv
module specgate_gate_chk #(
  parameter int IDX_W = 5,
  parameter int CSR_ADDR_W = 4,
  parameter logic [(1<<CSR_ADDR_W)-1:0] SAFE_MASK = '0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [IDX_W-1:0]      headSlot,
  input logic                  flushValid,
  input logic [IDX_W-1:0]      flushSlot,
  input logic                  reqValid,
  input logic [1:0]            reqKind,
  input logic [CSR_ADDR_W-1:0] reqCsr,
  input logic                  reqReady,
  input logic                  gntValid,
  input logic [IDX_W-1:0]      gntSlot,
  input logic [1:0]            gntKind,
  input logic                  stall
);
  logic [IDX_W-1:0] gntAge, flushAge;
  assign gntAge   = gntSlot - headSlot;
  assign flushAge = flushSlot - headSlot;

  // R7: grant and stall are exclusive
  a_r7_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(gntValid && stall));
  // R7: a stalled request is held next cycle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !reqReady);
  a_r7_persist: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (stall || gntValid || flushValid));
  // R5: stores leave only from the head
  a_r5_store_head: assert property (@(posedge clk) disable iff (!rstN)
    (gntValid && gntKind == 2'd3) |-> (gntSlot == headSlot));
  // R8: nothing inside a flush is granted
  a_r8_no_flushed_grant: assert property (@(posedge clk) disable iff (!rstN)
    (gntValid && flushValid) |-> (gntAge < flushAge));
  // R6: plain operations pass on arrival
  a_r6_plain: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqKind == 2'd0 && !flushValid) |-> gntValid);
  // R4: safe register reads pass on arrival
  a_r4_safe_csr: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqKind == 2'd2 && SAFE_MASK[reqCsr] && !flushValid)
      |-> gntValid);
endmodule

bind specgate_gate specgate_gate_chk #(
  .IDX_W(IDX_W), .CSR_ADDR_W(CSR_ADDR_W), .SAFE_MASK(CSR_SAFE_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .headSlot(headSlot),
  .flushValid(flushValid), .flushSlot(flushSlot),
  .reqValid(reqValid), .reqKind(reqKind), .reqCsr(reqCsr),
  .reqReady(reqReady), .gntValid(gntValid), .gntSlot(gntSlot),
  .gntKind(gntKind), .stall(stall)
);

// File: tb/specgate_gate_tb.sv
module specgate_gate_tb;
  localparam int DEPTH = 8;
  localparam int IW = 3;
  localparam int CW = 3;
  localparam logic [7:0] MASK = 8'b1010_0101;

  logic clk = 1'b0;
  logic rstN;
  logic [IW-1:0] headSlot, brAllocSlot, brResolveSlot, fltAllocSlot, fltClearSlot, flushSlot, reqSlot;
  logic brAllocValid, brResolveValid, fltAllocValid, fltClearValid, flushValid, reqValid;
  logic [1:0] reqKind;
  logic [CW-1:0] reqCsr;
  logic reqReady, gntValid, stall;
  logic [IW-1:0] gntSlot;
  logic [1:0] gntKind;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  specgate_gate #(.ROB_DEPTH(DEPTH), .CSR_ADDR_W(CW), .CSR_SAFE_MASK(MASK)) u_dut (
    .clk(clk), .rstN(rstN), .headSlot(headSlot),
    .brAllocValid(brAllocValid), .brAllocSlot(brAllocSlot),
    .brResolveValid(brResolveValid), .brResolveSlot(brResolveSlot),
    .fltAllocValid(fltAllocValid), .fltAllocSlot(fltAllocSlot),
    .fltClearValid(fltClearValid), .fltClearSlot(fltClearSlot),
    .flushValid(flushValid), .flushSlot(flushSlot),
    .reqValid(reqValid), .reqKind(reqKind), .reqSlot(reqSlot), .reqCsr(reqCsr),
    .reqReady(reqReady), .gntValid(gntValid), .gntSlot(gntSlot),
    .gntKind(gntKind), .stall(stall)
  );

  function automatic logic [IW-1:0] sl(input int h, input int off);
    return IW'((h + off) % DEPTH);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    brAllocValid = 0; brResolveValid = 0; fltAllocValid = 0; fltClearValid = 0;
    flushValid = 0; reqValid = 0; reqKind = 0; reqCsr = 0; reqSlot = 0;
    brAllocSlot = 0; brResolveSlot = 0; fltAllocSlot = 0; fltClearSlot = 0; flushSlot = 0;
  endtask

  task automatic doReset();
    idle(); rstN = 0; tick(); tick(); rstN = 1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    headSlot = 0;
    tick();
    doReset();
    // R10: reset state
    #1;
    chk("R10 ready", reqReady, 1); chk("R10 gnt", gntValid, 0); chk("R10 stall", stall, 0);
    reqValid = 1; reqKind = 1; reqSlot = 3; #1;
    chk("R10 barrier free after reset", gntValid, 1);
    tick(); idle();

    // R1/R2/R3: every head, blocker and barrier position
    for (int src = 0; src < 2; src++)
      for (int h = 0; h < DEPTH; h++)
        for (int a = 0; a < DEPTH; a++)
          for (int b = 0; b < DEPTH; b++) begin
            bit older;
            if (a == b) continue;
            doReset(); headSlot = IW'(h);
            if (src == 0) begin brAllocValid = 1; brAllocSlot = sl(h, a); end
            else begin fltAllocValid = 1; fltAllocSlot = sl(h, a); end
            tick(); idle();
            older = (a < b);
            reqValid = 1; reqKind = 1; reqSlot = sl(h, b); #1;
            chk(older ? (src == 0 ? "R1 held" : "R2 held") : "R3 younger ignored", gntValid, !older);
            chk("R7 stall", stall, older);
            tick(); idle();
            if (older) begin
              #1; chk("R7 stall kept", stall, 1); chk("R7 ready low", reqReady, 0);
              if (src == 0) begin brResolveValid = 1; brResolveSlot = sl(h, a); end
              else begin fltClearValid = 1; fltClearSlot = sl(h, a); end
              #1;
              chk(src == 0 ? "R1 release" : "R2 release", gntValid, 1);
              chk("R1 gnt slot", gntSlot, sl(h, b));
              tick(); idle(); #1;
              chk("R7 single grant", gntValid, 0); chk("R7 ready back", reqReady, 1);
            end
          end

    // R2: both kinds outstanding
    doReset(); headSlot = 2;
    brAllocValid = 1; brAllocSlot = 3; fltAllocValid = 1; fltAllocSlot = 4; tick(); idle();
    reqValid = 1; reqKind = 1; reqSlot = 6; tick(); idle();
    brResolveValid = 1; brResolveSlot = 3; #1;
    chk("R2 fault still holds", stall, 1); chk("R2 no gnt", gntValid, 0);
    tick(); idle();
    fltClearValid = 1; fltClearSlot = 4; #1;
    chk("R2 release both clear", gntValid, 1);
    tick(); idle();

    // R4: every control-register address
    for (int n = 0; n < (1 << CW); n++) begin
      doReset(); headSlot = 0;
      fltAllocValid = 1; fltAllocSlot = 1; tick(); idle();
      reqValid = 1; reqKind = 2; reqSlot = 2; reqCsr = CW'(n); #1;
      chk("R4 table", gntValid, int'(MASK[n]));
      chk("R4 stall", stall, int'(!MASK[n]));
      tick(); idle();
      if (!MASK[n]) begin
        fltClearValid = 1; fltClearSlot = 1; #1;
        chk("R4 unsafe release", gntValid, 1);
        chk("R4 gnt kind", gntKind, 2);
        tick(); idle();
      end
    end

    // R5: stores
    for (int h = 0; h < DEPTH; h++)
      for (int b = 0; b < DEPTH; b++) begin
        doReset(); headSlot = IW'(h);
        reqValid = 1; reqKind = 3; reqSlot = sl(h, b); #1;
        chk("R5 store at head", gntValid, b == 0);
        tick(); idle();
        if (b != 0) begin
          #1; chk("R5 store held", stall, 1);
          headSlot = sl(h, b); #1;
          chk("R5 store release", gntValid, 1);
          tick(); idle();
        end
      end

    // R6: plain ops
    doReset(); headSlot = 0;
    brAllocValid = 1; brAllocSlot = 1; fltAllocValid = 1; fltAllocSlot = 2; tick(); idle();
    reqValid = 1; reqKind = 0; reqSlot = 5; #1;
    chk("R6 plain passes", gntValid, 1); chk("R6 kind", gntKind, 0);
    tick(); idle();

    // R8/R9: flushes
    for (int h = 0; h < DEPTH; h++) begin
      doReset(); headSlot = IW'(h);
      brAllocValid = 1; brAllocSlot = sl(h, 1); tick(); idle();
      reqValid = 1; reqKind = 1; reqSlot = sl(h, 3); tick(); idle();
      flushValid = 1; flushSlot = sl(h, 4); #1;
      chk("R8 younger flush keeps stall", stall, 1); chk("R8 no gnt", gntValid, 0);
      tick(); idle();
      flushValid = 1; flushSlot = sl(h, 2); #1;
      chk("R8 cancel gnt", gntValid, 0); chk("R8 cancel stall", stall, 0);
      tick(); idle(); #1;
      chk("R8 ready back", reqReady, 1);
      reqValid = 1; reqKind = 1; reqSlot = sl(h, 2); #1;
      chk("R9 older bit kept", stall, 1);
      tick(); idle();
      brResolveValid = 1; brResolveSlot = sl(h, 1); #1;
      chk("R9 release", gntValid, 1);
      tick(); idle();

      doReset(); headSlot = IW'(h);
      brAllocValid = 1; brAllocSlot = sl(h, 5); tick(); idle();
      flushValid = 1; flushSlot = sl(h, 4); tick(); idle();
      reqValid = 1; reqKind = 1; reqSlot = sl(h, 6); #1;
      chk("R9 flushed bit cleared", gntValid, 1);
      tick(); idle();
    end

    finishRun();
  end
endmodule